// File: doc/BRIEF.md
# Transmit Power-State Sequencer

This block decides, cycle by cycle, which parts of a dual-channel transmit datapath are powered and clocked. Three control requests feed it. The first is a board-level power-down pin. The other two are register bits, one for a light sleep and one for a deep shutdown. The block turns these into four enables for the datapath: a clock enable for the interpolation filters, an enable for the converter's output current, a flag that keeps the analog biases alive, and a ready flag that tells the data source samples are being used.

Each low-power state has its own exit rule. Light sleep only silences the converter current, so leaving it is immediate. Pin power-down stops the clocks but keeps the biases up, and leaving it takes a programmable wake interval (sized for about 10 µs). Deep shutdown also drops the biases. Leaving it restarts the clocks at once, but ready is withheld for a programmable number of cycles while the filters flush the random contents they picked up. After reset the block runs that same flush once.

Top module: `tx_pwr_seq`

## Requirements
- R1: Each control input passes through two flip-flops, and all four outputs are registered. An output reacts on the third rising clock edge after an input changes, never earlier.
- R2: With the pin request active and deep shutdown inactive, the outputs are clock enable 0, converter enable 0, bias 1 and ready 0.
- R3: When the pin request is released, the clock enable rises at once. Ready and the converter enable rise exactly WAKE_CYCLES cycles later.
- R4: With only the sleep request active, the converter enable is 0 and clock enable, bias and ready stay 1.
- R5: Releasing sleep restores the converter enable with the R1 latency, and ready never drops across entry into or exit from sleep.
- R6: With deep shutdown active, all four outputs are 0.
- R7: When deep shutdown is released, clock enable and bias rise at once. Ready and the converter enable stay 0 for exactly FLUSH_CYCLES cycles, and the converter enable is never 1 while ready is 0.
- R8: Priority is deep shutdown over pin over sleep. If deep shutdown is released while the pin is still active, the block enters pin power-down.
- R9: While reset is asserted, the outputs are clock enable 1, converter enable 0, bias 1 and ready 0. After reset is released, a full flush of FLUSH_CYCLES cycles runs before ready rises.
- R10: A pin or deep-shutdown request that arrives during a flush or wake interval aborts it, and the next exit starts a fresh interval of full length. A sleep request during an interval is held off until the interval ends, then the block enters sleep with ready 1 and the converter enable 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| pin_pd_i | input | 1 | External power-down request (asynchronous) |
| reg_sleep_i | input | 1 | Sleep request from the register file |
| reg_full_pd_i | input | 1 | Deep-shutdown request from the register file |
| clk_en_o | output | 1 | Clock enable for the interpolation filters |
| dac_en_o | output | 1 | Converter output-current enable |
| bias_on_o | output | 1 | Keep analog biases alive |
| ready_o | output | 1 | Datapath is accepting and converting samples |

## Verification
The hardest situations to reach from the ports are the interrupted intervals: a power request that lands in the middle of a flush or wake count, and a sleep request that is pending when such a count expires. The stimulus drives requests at falling edges and counts edges from the known synchroniser latency. This lets it place a pin request part-way into a flush and re-enter deep shutdown part-way into another. It then confirms that the next exit waits the full interval. Overlapping requests are also raised together and dropped one at a time, which walks the priority order down from deep shutdown to pin to sleep.

// File: rtl/tx_pwr_pkg.sv
package tx_pwr_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_PINOFF  = 3'd2,
    ST_PINWAKE = 3'd3,
    ST_FULLOFF = 3'd4,
    ST_FLUSH   = 3'd5
  } pwr_state_e;

  typedef struct packed {
    logic clk_en;
    logic dac_en;
    logic bias_on;
    logic ready;
  } pwr_out_t;

  // Output decode for every power state.
  function automatic pwr_out_t state_outputs(pwr_state_e s);
    pwr_out_t o;
    unique case (s)
      ST_RUN:     o = '{clk_en: 1'b1, dac_en: 1'b1, bias_on: 1'b1, ready: 1'b1};
      ST_SLEEP:   o = '{clk_en: 1'b1, dac_en: 1'b0, bias_on: 1'b1, ready: 1'b1};
      ST_PINOFF:  o = '{clk_en: 1'b0, dac_en: 1'b0, bias_on: 1'b1, ready: 1'b0};
      ST_PINWAKE: o = '{clk_en: 1'b1, dac_en: 1'b0, bias_on: 1'b1, ready: 1'b0};
      ST_FULLOFF: o = '{clk_en: 1'b0, dac_en: 1'b0, bias_on: 1'b0, ready: 1'b0};
      ST_FLUSH:   o = '{clk_en: 1'b1, dac_en: 1'b0, bias_on: 1'b1, ready: 1'b0};
      default:    o = '{clk_en: 1'b0, dac_en: 1'b0, bias_on: 1'b0, ready: 1'b0};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/tx_pwr_sync.sv
module tx_pwr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/tx_pwr_timer.sv
module tx_pwr_timer #(
  parameter int          CW      = 8,
  parameter logic [CW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                     cnt_d = load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  // R10
  fresh_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i != '0) |=> !done_o);

  // R10
  hold_without_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !dec_i) |=> $stable(done_o));

endmodule

// File: rtl/tx_pwr_fsm.sv
module tx_pwr_fsm
  import tx_pwr_pkg::*;
#(
  parameter int FLUSH_CYCLES = 54,
  parameter int WAKE_CYCLES  = 500,
  parameter int CW           = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_s_i,
  input  logic          sleep_s_i,
  input  logic          full_s_i,
  input  logic          tmr_done_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          tmr_dec_o,
  output logic          clk_en_o,
  output logic          dac_en_o,
  output logic          bias_on_o,
  output logic          ready_o
);

  localparam logic [CW-1:0] FLUSH_LOAD = CW'(FLUSH_CYCLES - 1);
  localparam logic [CW-1:0] WAKE_LOAD  = CW'(WAKE_CYCLES - 1);

  pwr_state_e state_q, state_d;
  pwr_out_t   out_d;

  // Next-state logic: deep shutdown, then pin, then sleep.
  always_comb begin
    state_d = state_q;
    if (full_s_i) begin
      state_d = ST_FULLOFF;
    end else if (pin_s_i) begin
      state_d = ST_PINOFF;
    end else begin
      unique case (state_q)
        ST_FULLOFF: state_d = ST_FLUSH;
        ST_PINOFF:  state_d = ST_PINWAKE;
        ST_FLUSH, ST_PINWAKE:
          if (tmr_done_i) state_d = sleep_s_i ? ST_SLEEP : ST_RUN;
        ST_RUN, ST_SLEEP:
          state_d = sleep_s_i ? ST_SLEEP : ST_RUN;
        default: state_d = ST_FULLOFF;
      endcase
    end
  end

  // Interval timer control.
  always_comb begin
    tmr_load_o = (state_d != state_q) &&
                 (state_d == ST_FLUSH || state_d == ST_PINWAKE);
    tmr_val_o  = (state_d == ST_PINWAKE) ? WAKE_LOAD : FLUSH_LOAD;
    tmr_dec_o  = (state_q == ST_FLUSH) || (state_q == ST_PINWAKE);
    out_d      = state_outputs(state_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_FLUSH;
      clk_en_o  <= 1'b1;
      dac_en_o  <= 1'b0;
      bias_on_o <= 1'b1;
      ready_o   <= 1'b0;
    end else begin
      state_q   <= state_d;
      clk_en_o  <= out_d.clk_en;
      dac_en_o  <= out_d.dac_en;
      bias_on_o <= out_d.bias_on;
      ready_o   <= out_d.ready;
    end
  end

  // R2
  pin_gates_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_s_i && !full_s_i) |=> (!clk_en_o && bias_on_o && !ready_o));

  // R6
  full_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_s_i |=> (!clk_en_o && !dac_en_o && !bias_on_o && !ready_o));

  // R7
  no_stale_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> !dac_en_o);

  // R3
  ready_after_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(tmr_done_i));

  // R4
  sleep_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && sleep_s_i && !pin_s_i && !full_s_i) |=>
      (ready_o && clk_en_o && !dac_en_o));

endmodule

// File: rtl/tx_pwr_seq.sv
module tx_pwr_seq #(
  parameter int FLUSH_CYCLES = 54,
  parameter int WAKE_CYCLES  = 500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_pd_i,
  input  logic reg_sleep_i,
  input  logic reg_full_pd_i,
  output logic clk_en_o,
  output logic dac_en_o,
  output logic bias_on_o,
  output logic ready_o
);

  localparam int MAX_INTERVAL = (FLUSH_CYCLES > WAKE_CYCLES) ? FLUSH_CYCLES : WAKE_CYCLES;
  localparam int CW           = $clog2(MAX_INTERVAL + 1);

  logic [2:0]    req_s;
  logic          tmr_load, tmr_dec, tmr_done;
  logic [CW-1:0] tmr_val;

  tx_pwr_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({reg_full_pd_i, pin_pd_i, reg_sleep_i}),
    .sync_o  (req_s)
  );

  tx_pwr_timer #(
    .CW      (CW),
    .RST_VAL (CW'(FLUSH_CYCLES - 1))
  ) i_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .dec_i      (tmr_dec),
    .done_o     (tmr_done)
  );

  tx_pwr_fsm #(
    .FLUSH_CYCLES (FLUSH_CYCLES),
    .WAKE_CYCLES  (WAKE_CYCLES),
    .CW           (CW)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_s_i    (req_s[1]),
    .sleep_s_i  (req_s[0]),
    .full_s_i   (req_s[2]),
    .tmr_done_i (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .tmr_dec_o  (tmr_dec),
    .clk_en_o   (clk_en_o),
    .dac_en_o   (dac_en_o),
    .bias_on_o  (bias_on_o),
    .ready_o    (ready_o)
  );

endmodule

// File: tb/test_tx_pwr_seq.sv
module test_tx_pwr_seq;

  localparam int FLUSH = 54;
  localparam int WAKE  = 500;

  // Output nibble order: {clk_en, dac_en, bias_on, ready}
  localparam logic [3:0] O_RUN   = 4'b1111;
  localparam logic [3:0] O_SLEEP = 4'b1011;
  localparam logic [3:0] O_PIN   = 4'b0010;
  localparam logic [3:0] O_FULL  = 4'b0000;
  localparam logic [3:0] O_WAIT  = 4'b1010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, slp = 1'b0, full = 1'b0;
  logic clk_en, dac_en, bias_on, ready;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  bit mon_ready = 1'b0;

  always #10 clk = ~clk;

  tx_pwr_seq #(.FLUSH_CYCLES(FLUSH), .WAKE_CYCLES(WAKE)) i_tx_pwr_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .pin_pd_i      (pin),
    .reg_sleep_i   (slp),
    .reg_full_pd_i (full),
    .clk_en_o      (clk_en),
    .dac_en_o      (dac_en),
    .bias_on_o     (bias_on),
    .ready_o       (ready)
  );

  function automatic logic [3:0] outs();
    return {clk_en, dac_en, bias_on, ready};
  endfunction

  task automatic check(string req, logic [3:0] exp);
    n_checks++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req, outs(), exp, $time);
    end
  endtask

  task automatic after(int n, string req, logic [3:0] exp);
    repeat (n) @(negedge clk);
    check(req, exp);
  endtask

  // Ready must stay high through sleep entry and exit (R5).
  always @(negedge clk) begin
    if (mon_ready && !ready) begin
      n_checks++;
      n_fail++;
      $display("FAIL R5: ready=%b expected=1 during sleep toggle", ready);
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset value", O_WAIT);
    rst_n = 1'b1;
    after(FLUSH - 1, "R9 flush after reset", O_WAIT);
    after(1, "R9 ready after reset flush", O_RUN);
  endtask

  task automatic t_sleep();
    slp = 1'b1;
    mon_ready = 1'b1;
    after(2, "R1 sleep latency", O_RUN);
    after(1, "R4 sleep entry", O_SLEEP);
    after(6, "R4 sleep held", O_SLEEP);
    slp = 1'b0;
    after(2, "R1 sleep exit latency", O_SLEEP);
    after(1, "R5 sleep exit immediate", O_RUN);
    mon_ready = 1'b0;
  endtask

  task automatic t_pin();
    pin = 1'b1;
    after(2, "R1 pin latency", O_RUN);
    after(1, "R2 pin power-down", O_PIN);
    pin = 1'b0;
    after(3, "R3 wake clocks first", O_WAIT);
    after(WAKE - 1, "R3 wake interval", O_WAIT);
    after(1, "R3 ready after wake", O_RUN);
  endtask

  task automatic t_full();
    full = 1'b1;
    after(3, "R6 full power-down", O_FULL);
    full = 1'b0;
    after(3, "R7 flush clocks first", O_WAIT);
    after(FLUSH - 1, "R7 flush interval", O_WAIT);
    after(1, "R7 ready after flush", O_RUN);
  endtask

  task automatic t_priority();
    full = 1'b1; pin = 1'b1; slp = 1'b1;
    after(3, "R8 full over all", O_FULL);
    full = 1'b0;
    after(3, "R8 pin over sleep", O_PIN);
    pin = 1'b0;
    after(3, "R8 wake after pin", O_WAIT);
    after(WAKE - 1, "R10 sleep held off", O_WAIT);
    after(1, "R10 sleep after wake", O_SLEEP);
    slp = 1'b0;
    after(3, "R5 sleep released", O_RUN);
  endtask

  task automatic t_abort();
    full = 1'b1;
    after(3, "R6 full again", O_FULL);
    full = 1'b0;
    after(3, "R7 flush start", O_WAIT);
    after(10, "R10 mid flush", O_WAIT);
    pin = 1'b1;
    after(3, "R10 pin aborts flush", O_PIN);
    pin = 1'b0;
    after(3, "R10 wake start", O_WAIT);
    after(WAKE - 1, "R10 full wake interval", O_WAIT);
    after(1, "R10 ready after wake", O_RUN);
    full = 1'b1;
    after(3, "R6 full", O_FULL);
    full = 1'b0;
    after(20, "R10 mid flush 2", O_WAIT);
    full = 1'b1;
    after(3, "R10 full aborts flush", O_FULL);
    full = 1'b0;
    after(3, "R10 fresh flush", O_WAIT);
    after(FLUSH - 1, "R10 full-length flush", O_WAIT);
    after(1, "R10 ready after fresh flush", O_RUN);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sleep();
    t_pin();
    t_full();
    t_priority();
    t_abort();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

endmodule